// File: doc/BRIEF.md
# Boxed single-precision sign-injection unit

This block performs the three single-precision sign-injection operations (take sign, take inverted sign, combine signs by xor) on 64-bit floating-point register values. Each 32-bit value sits in the low half of a 64-bit word, and a correct word has an upper half that is all ones. Both operands are checked for this boxing before use. An operand that fails the check is replaced by the boxed canonical quiet NaN before the sign operation.

One operation is accepted each cycle on a valid strobe. The result comes out of a register one cycle later, together with a result-valid flag and a one-cycle pulse that marks the floating-point state as modified. A reserved operation code yields no result and raises an illegal-operation flag in that same output cycle. NaN payloads of correctly boxed operands are neither inspected nor quieted. Move, negate and absolute value are simply the general operations with both operands equal.

Top module: `sgnj_box_unit`

## Requirements
- R1: An operand counts as properly boxed only when bits 63:32 are all ones. Any other operand is used as 64'hFFFFFFFF7FC00000.
- R2: With op 2'b00 (take sign), result[30:0] equals checked A[30:0], and result[63:31] equals checked B[63:31].
- R3: With op 2'b01 (inverted sign), result bit 31 equals the inverse of checked B bit 31. Every other bit equals checked A.
- R4: With op 2'b10 (xor sign), result bit 31 equals checked A[31] xor checked B[31]. Every other bit equals checked A.
- R5: Every valid result has result[63:32] all ones.
- R6: The result, res_valid and dirty appear on the clock edge after the one that samples in_valid high with a legal op. Otherwise res_valid and dirty are low.
- R7: dirty is high exactly when res_valid is high, so it pulses for one cycle per completed operation.
- R8: Op 2'b11 raises illegal for one cycle, with the same timing as R6, and res_valid and dirty stay low.
- R9: During a synchronous active-low reset, res_valid, dirty and illegal are driven low.
- R10: When A equals B, the results equal the general formulas: move, negate and absolute value. Signaling NaN payloads pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| in_valid | input | 1 | operation strobe |
| op | input | 2 | 00 take sign, 01 inverted sign, 10 xor sign, 11 reserved |
| opnd_a | input | 64 | first operand (magnitude source) |
| opnd_b | input | 64 | second operand (sign source) |
| result | output | 64 | registered boxed result |
| res_valid | output | 1 | result valid |
| dirty | output | 1 | floating-point state modified pulse |
| illegal | output | 1 | reserved op seen |

## Verification
Boxing repair and sign injection can act in the same cycle. When one or both operands are badly boxed, the substituted NaN becomes the source of the magnitude, the sign or the box. The bench sweeps every combination of boxed and unboxed A and B, each sign, all four op codes and equal-operand cases. It judges each result against a model built arithmetically from R1 to R4.

// File: rtl/sgnj_pkg.sv
// Shared definitions for the sign-injection unit.
// Assumes the boxing width is half the register width.
package sgnj_pkg;
    localparam int FLEN = 64;
    localparam int SLEN = 32;
    localparam logic [SLEN-1:0] CANON_QNAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        OP_TAKE = 2'b00,
        OP_INV  = 2'b01,
        OP_XOR  = 2'b10,
        OP_RSV  = 2'b11
    } sgnj_op_e;
endpackage

// File: rtl/sgnj_box_check.sv
// Checks the boxing of one operand and substitutes the boxed canonical NaN
// when the upper bits are not all ones. Purely combinational.
module sgnj_box_check
    import sgnj_pkg::*;
#(
    parameter int W  = FLEN,
    parameter int NW = SLEN
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] chk
);
    localparam int UW = W - NW;

    // Pass a correctly boxed operand through, otherwise use the boxed NaN.
    always_comb begin
        if (&raw[W-1:NW]) chk = raw;
        else              chk = {{UW{1'b1}}, CANON_QNAN};
    end
endmodule

// File: rtl/sgnj_core.sv
// Combinational sign injection on already-checked operands.
// Assumes both inputs are properly boxed, so the kept box bits stay ones.
module sgnj_core
    import sgnj_pkg::*;
#(
    parameter int W  = FLEN,
    parameter int NW = SLEN
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int SB = NW - 1;

    // Pick the sign source per operation and merge it with A's magnitude.
    always_comb begin
        y = a;
        unique case (op)
            OP_TAKE: y = {b[W-1:SB], a[SB-1:0]};
            OP_INV:  y[SB] = ~b[SB];
            OP_XOR:  y[SB] = a[SB] ^ b[SB];
            default: y = a;
        endcase
    end
endmodule

// File: rtl/sgnj_box_unit.sv
// Top level: checks operand boxing, injects the sign, registers the result.
// Assumes one operation per cycle with no back-pressure. Latency is one cycle.
module sgnj_box_unit
    import sgnj_pkg::*;
#(
    parameter int W  = FLEN,
    parameter int NW = SLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         res_valid,
    output logic         dirty,
    output logic         illegal
);
    logic [W-1:0] a_chk, b_chk, y_comb;
    logic         legal;

    sgnj_box_check #(.W(W), .NW(NW)) u_chk_a (.raw(opnd_a), .chk(a_chk));
    sgnj_box_check #(.W(W), .NW(NW)) u_chk_b (.raw(opnd_b), .chk(b_chk));
    sgnj_core      #(.W(W), .NW(NW)) u_core  (.op(op), .a(a_chk), .b(b_chk), .y(y_comb));

    assign legal = (op != OP_RSV);

    // Register the status flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            dirty     <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= in_valid && legal;
            dirty     <= in_valid && legal;
            illegal   <= in_valid && !legal;
        end
    end

    // Capture the result whenever a legal operation is accepted.
    always_ff @(posedge clk) begin
        if (in_valid && legal) result <= y_comb;
    end

    AST_BOXED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (&result[W-1:NW])); // R5
    AST_DIRTY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dirty == res_valid); // R7
    AST_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !res_valid && !dirty); // R8
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'b11) |=> res_valid); // R6
    AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> illegal); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid && !illegal); // R6
endmodule

// File: tb/tb_sgnj_box_unit.sv
module tb_sgnj_box_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [63:0] result;
    logic        res_valid, dirty, illegal;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    sgnj_box_unit dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .res_valid(res_valid), .dirty(dirty), .illegal(illegal));

    function automatic logic [63:0] fix(input logic [63:0] v); // R1 model
        return (v >= 64'hFFFF_FFFF_0000_0000) ? v : 64'hFFFF_FFFF_7FC0_0000;
    endfunction

    function automatic logic [63:0] model(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] ca, cb, sm;
        ca = fix(a); cb = fix(b);
        sm = 64'h0000_0000_8000_0000;
        case (o)
            2'b00: return (cb & ~64'h7FFF_FFFF) | (ca & 64'h7FFF_FFFF);   // R2
            2'b01: return (ca & ~sm) | (~cb & sm);                         // R3
            default: return ca ^ (cb & sm);                                // R4
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b, input string req);
        @(negedge clk);
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (o == 2'b11) begin
            chk({req, " R8 illegal"}, {63'd0, illegal}, 64'd1);
            chk({req, " R8 no valid"}, {62'd0, res_valid, dirty}, 64'd0);
        end else begin
            chk({req, " R6 valid"}, {63'd0, res_valid}, 64'd1);
            chk({req, " R7 dirty"}, {63'd0, dirty}, 64'd1);
            chk({req, " R5 box"}, {32'd0, result[63:32]}, 64'hFFFF_FFFF);
            chk(req, result, model(o, a, b));
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] pats [8];
        pats[0] = 64'hFFFF_FFFF_3F80_0000;
        pats[1] = 64'hFFFF_FFFF_BF80_0000;
        pats[2] = 64'hFFFF_FFFF_7F80_0001; // signaling NaN, R10
        pats[3] = 64'hFFFF_FFFF_FF81_2345;
        pats[4] = 64'h0000_0000_3F80_0000; // unboxed
        pats[5] = 64'hFFFF_FFFE_BF80_0000; // one bit missing
        pats[6] = 64'h7FFF_FFFF_8000_0000;
        pats[7] = 64'hFFFF_FFFF_0000_0000; // exact bound
        repeat (3) @(negedge clk);
        chk("R9 reset flags", {61'd0, res_valid, dirty, illegal}, 64'd0);
        rst_n = 1'b1;
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(o[1:0], pats[i], pats[j], (i == j) ? "R10 equal" : "R1-R4 sweep");
        run(2'b01, pats[4], pats[4], "R1 R10 negate unboxed");
        chk("R1 subst NaN neg", result, 64'hFFFF_FFFF_FFC0_0000);
        run(2'b10, pats[2], pats[2], "R10 abs sNaN");
        chk("R10 sNaN kept", result, 64'hFFFF_FFFF_7F80_0001);
        @(negedge clk);
        chk("R6 idle", {62'd0, res_valid, illegal}, 64'd0);
        @(negedge clk); in_valid = 1'b1; op = 2'b00;
        opnd_a = pats[0]; opnd_b = pats[1];
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset wins", {61'd0, res_valid, dirty, illegal}, 64'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule